// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 14-bit successive-approximation converter. A falling edge on the active-low start input launches a conversion. The sequencer then presents a trial code to an external comparator, one bit at a time from the top bit down, and keeps or clears each bit according to the comparator answer. One extra trial then tests the input against a point a fixed margin above positive full scale. At the end the result is copied into output latches in two's-complement form, together with an out-of-range flag.

The analog side is reduced to two signals. `trial_o` is the code the DAC would produce, in offset binary (0 is negative full scale). `cmp_i` is the comparator answer, high when the input is at or above that trial level. A testbench closes the loop with an ideal model. A bit-period parameter sets how many clocks each decision takes. The default of 5 clocks gives 15 steps of 20 ns each at 250 MHz, which is 300 ns per conversion.

Result and flag are plain latched outputs. No handshake is used, because the converter cannot stall. The rising edge of `busy_n` marks new data.

Top module: `sar_seq`

## Requirements
- R1: A high-to-low transition of `start_n`, sampled on a clock edge while idle, starts a conversion; `busy_n` is low from the next cycle.
- R2: While a conversion runs, further falling edges of `start_n` have no effect, and this includes an edge sampled on the final edge of the conversion. Holding `start_n` low past the end of a conversion does not start a new one.
- R3: `busy_n` stays low for exactly (W+1)*BIT_CLKS cycles (75 with defaults) and then returns high.
- R4: Bits are decided from the top down. The first trial code is 2^(W-1) (8192). `trial_o` changes only on a step boundary, every BIT_CLKS cycles.
- R5: For an ideal comparator with input level v in offset-binary LSBs, the result is min(v, 2^W-1) with its top bit inverted. v = 8192 (bipolar zero) gives `data_o` = 0, and v = 16383 gives 0x1FFF.
- R6: `data_o` and `ovr_o` keep the previous result for the whole conversion. They change only on the edge where `busy_n` returns high.
- R7: `ovr_o` is set when the result is the most negative code, 0x2000 (offset-binary 0, for example v = 0).
- R8: The final step drives `trial_o` = 2^W-1+MARGIN (16447). `ovr_o` is set when the comparator answers high on that step, so v = 16446 leaves it clear and v = 16447 sets it.
- R9: After reset, `busy_n` = 1, `data_o` = 0, `ovr_o` = 0 and `trial_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_n | input | 1 | Active-low start; a falling edge requests a conversion |
| cmp_i | input | 1 | Comparator answer: 1 when the input is at or above `trial_o` |
| trial_o | output | W+1 | Offset-binary trial code to the DAC; the top bit is used only by the margin trial |
| busy_n | output | 1 | Low while a conversion runs |
| data_o | output | W | Latched two's-complement result |
| ovr_o | output | 1 | Latched out-of-range flag |

## Verification
The collision that matters is a new start edge landing on the same clock edge as the final margin decision, when the sequencer returns to idle. The bench drops `start_n` on the half-cycle just before that edge. It then checks that `busy_n` stays high afterwards and that the scoreboard receives no extra result. A second coincidence is the out-of-range flag, which has two sources in the same closing cycle: the margin trial and the most-negative result. These are provoked with inputs at 0, at 16446 and at 16447.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BITS   = 2'd1,
    ST_MARGIN = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_start_edge.sv
`timescale 1ns/1ps
module sar_start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  output logic fall
);
  logic start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 1'b1;
    else        start_q <= start_n;
  end

  assign fall = start_q & ~start_n;
endmodule

// File: rtl/sar_bit_timer.sv
`timescale 1ns/1ps
module sar_bit_timer #(
  parameter int BIT_CLKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic step_stb
);
  localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);

  logic [CW-1:0] cnt;

  assign step_stb = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || step_stb) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sar_core.sv
`timescale 1ns/1ps
module sar_core
  import sar_pkg::*;
#(
  parameter int W      = 14,
  parameter int MARGIN = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fall,
  input  logic         step_stb,
  input  logic         cmp_i,
  output logic         run,
  output logic         done,
  output logic [W-1:0] code,
  output logic [W:0]   trial
);
  localparam int IW = $clog2(W);
  localparam logic [W:0]    LIMIT = (W+1)'((1 << W) - 1 + MARGIN);
  localparam logic [IW-1:0] TOP   = IW'(W - 1);

  sar_state_e    state;
  logic [IW-1:0] idx;
  logic [IW-1:0] idx_dn;

  assign idx_dn = idx - 1'b1;
  assign run    = (state != ST_IDLE);
  assign done   = (state == ST_MARGIN) && step_stb;
  assign trial  = (state == ST_MARGIN) ? LIMIT : {1'b0, code};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      code  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fall) begin
            state <= ST_BITS;
            idx   <= TOP;
            code  <= {1'b1, {(W-1){1'b0}}};
          end
        end
        ST_BITS: begin
          if (step_stb) begin
            code[idx] <= cmp_i;
            if (idx == '0) begin
              state <= ST_MARGIN;
            end else begin
              code[idx_dn] <= 1'b1;
              idx          <= idx_dn;
            end
          end
        end
        ST_MARGIN: begin
          if (step_stb) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_result_latch.sv
`timescale 1ns/1ps
module sar_result_latch #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done,
  input  logic         cmp_i,
  input  logic [W-1:0] code,
  output logic [W-1:0] data_o,
  output logic         ovr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_o <= '0;
      ovr_o  <= 1'b0;
    end else if (done) begin
      data_o <= {~code[W-1], code[W-2:0]};
      ovr_o  <= cmp_i | (code == '0);
    end
  end
endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq #(
  parameter int W        = 14,
  parameter int BIT_CLKS = 5,
  parameter int MARGIN   = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_n,
  input  logic         cmp_i,
  output logic [W:0]   trial_o,
  output logic         busy_n,
  output logic [W-1:0] data_o,
  output logic         ovr_o
);
  logic         fall;
  logic         run;
  logic         step_stb;
  logic         done;
  logic [W-1:0] code;

  sar_start_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_n (start_n),
    .fall    (fall)
  );

  sar_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .step_stb (step_stb)
  );

  sar_core #(.W(W), .MARGIN(MARGIN)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall     (fall),
    .step_stb (step_stb),
    .cmp_i    (cmp_i),
    .run      (run),
    .done     (done),
    .code     (code),
    .trial    (trial_o)
  );

  sar_result_latch #(.W(W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done),
    .cmp_i  (cmp_i),
    .code   (code),
    .data_o (data_o),
    .ovr_o  (ovr_o)
  );

  assign busy_n = ~run;
endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk #(
  parameter int W        = 14,
  parameter int BIT_CLKS = 5,
  parameter int MARGIN   = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_n,
  input logic         busy_n,
  input logic [W-1:0] data_o,
  input logic         ovr_o,
  input logic [W:0]   trial_o,
  input logic         step_stb
);
  localparam int TOT = (W + 1) * BIT_CLKS;
  localparam int LW  = $clog2(TOT + 1) + 1;
  localparam logic [W:0] LIMIT = (W+1)'((1 << W) - 1 + MARGIN);
  localparam logic [W:0] FIRST = (W+1)'(1 << (W - 1));

  logic [LW-1:0] lowcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || busy_n) lowcnt <= '0;
    else                  lowcnt <= lowcnt + 1'b1;
  end

  p_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_n) && busy_n |=> !busy_n);

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> lowcnt == LW'(TOT));

  p_busy_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> lowcnt < LW'(TOT));

  p_first_trial_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> trial_o == FIRST);

  p_trial_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n && $past(!busy_n) && !$past(step_stb) |-> $stable(trial_o));

  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> $stable(data_o) && $stable(ovr_o));

  p_neg_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) && data_o == {1'b1, {(W-1){1'b0}}} |-> ovr_o);

  p_margin_trial_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n && lowcnt >= LW'(W * BIT_CLKS) |-> trial_o == LIMIT);

  p_ovr_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovr_o) |-> $rose(busy_n));
endmodule

bind sar_seq sar_seq_chk #(.W(W), .BIT_CLKS(BIT_CLKS), .MARGIN(MARGIN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_n  (start_n),
  .busy_n   (busy_n),
  .data_o   (data_o),
  .ovr_o    (ovr_o),
  .trial_o  (trial_o),
  .step_stb (step_stb)
);

// File: tb/sim_sar_seq.sv
`timescale 1ns/1ps
module sim_sar_seq;
  localparam int W     = 14;
  localparam int B     = 5;
  localparam int MG    = 64;
  localparam int TOT   = (W + 1) * B;
  localparam int FSMAX = (1 << W) - 1;
  localparam int LIMIT = FSMAX + MG;

  typedef struct packed {
    logic [W-1:0] d;
    logic         o;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_n = 1'b1;
  logic         cmp;
  logic [W:0]   trial;
  logic         busy_n;
  logic [W-1:0] data;
  logic         ovr;
  int           vin = 0;

  int   nchk = 0;
  int   nerr = 0;
  int   lowcnt = 0;
  bit   prev_low = 1'b0;
  bit   finished = 1'b0;
  exp_t q[$];
  logic [W-1:0] prev_d = '0;
  logic         prev_o = 1'b0;

  always #2 clk = ~clk;

  assign cmp = (vin >= int'(trial));

  sar_seq #(.W(W), .BIT_CLKS(B), .MARGIN(MG)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_n (start_n),
    .cmp_i   (cmp),
    .trial_o (trial),
    .busy_n  (busy_n),
    .data_o  (data),
    .ovr_o   (ovr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: one result per busy_n rising, compared with the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (!busy_n) begin
        lowcnt++;
      end else if (prev_low) begin
        check(lowcnt == TOT, "R3 busy length", lowcnt, TOT);
        if (q.size() == 0) begin
          check(1'b0, "R2 unexpected result", int'(data), -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(data == e.d, "R5 result", int'(data), int'(e.d));
          check(ovr == e.o, "R7/R8 out-of-range", int'(ovr), int'(e.o));
        end
        lowcnt = 0;
      end
      prev_low = !busy_n;
    end
  end

  // mode 0 plain, 1 extra start mid-conversion, 2 start on final edge, 3 start held low
  task automatic run_conv(input int v, input int mode);
    exp_t e;
    int   c;
    c   = (v > FSMAX) ? FSMAX : ((v < 0) ? 0 : v);
    e.d = W'(c) ^ W'(1 << (W - 1));
    e.o = (c == 0) || (v >= LIMIT);
    vin = v;
    q.push_back(e);
    @(negedge clk);
    start_n = 1'b0;
    for (int n = 1; n <= TOT + 3; n++) begin
      @(negedge clk);
      if (n == 1) begin
        start_n = (mode == 3) ? 1'b0 : 1'b1;
        check(busy_n == 1'b0, "R1 busy low after start", int'(busy_n), 0);
        check(int'(trial) == (1 << (W - 1)), "R4 first trial", int'(trial), 1 << (W - 1));
      end
      if (mode == 1 && n == 10) start_n = 1'b0;
      if (mode == 1 && n == 12) start_n = 1'b1;
      if (n == 20) begin
        check(data == prev_d, "R6 data held", int'(data), int'(prev_d));
        check(ovr == prev_o, "R6 flag held", int'(ovr), int'(prev_o));
      end
      if (n == W * B + 1)
        check(int'(trial) == LIMIT, "R8 margin trial", int'(trial), LIMIT);
      if (mode == 2 && n == TOT) start_n = 1'b0;
      if ((mode == 2 || mode == 3) && n == TOT + 3) begin
        check(busy_n == 1'b1, "R2 no restart", int'(busy_n), 1);
        start_n = 1'b1;
      end
    end
    prev_d = e.d;
    prev_o = e.o;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_n == 1'b1, "R9 reset busy", int'(busy_n), 1);
    check(data == '0, "R9 reset data", int'(data), 0);
    check(ovr == 1'b0, "R9 reset flag", int'(ovr), 0);
    check(trial == '0, "R9 reset trial", int'(trial), 0);

    run_conv(8192, 0);    // R5 bipolar zero
    run_conv(0, 0);       // R7 most negative
    run_conv(1, 1);       // R2 extra edge mid-run
    run_conv(16383, 0);   // R5 positive full scale
    run_conv(16446, 2);   // R8 just below margin, R2 edge on final step
    run_conv(16447, 0);   // R8 at margin
    run_conv(30000, 3);   // R8 far over, R2 held low
    run_conv(12345, 0);
    run_conv(5000, 1);
    run_conv(8191, 0);

    repeat (10) @(negedge clk);
    check(q.size() == 0, "R2 pending results", q.size(), 0);
    check(busy_n == 1'b1, "R3 idle at end", int'(busy_n), 1);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule